// File: doc/BRIEF.md
# Binary64 Floating-Point Comparator

This unit compares two IEEE 754 double-precision operands and answers one of three questions about them: are they equal, is the first strictly below the second, or is the first below or equal to the second. It serves the compare instructions of a processor pipeline that has a double-precision floating-point extension. The answer is a single bit, zero-extended to the integer register width. Alongside it comes a 5-bit exception vector laid out like the accrued floating-point flags. Only the invalid-operation bit of that vector can ever be set by this unit.

The issuing stage presents an operation code and both operands with a valid strobe. One clock later the registered answer and flags appear, together with an output valid. Quiet and signaling NaNs, signed zeros, infinities and subnormals are all classified from the raw bit patterns. Equality stays silent for quiet NaNs but raises invalid for signaling ones. Both ordered comparisons raise invalid for any NaN.

Top module: `fp64_cmp_unit`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock edge. `result` and `flags` are registered and belong to the operation accepted on that edge. Reset (active-low `rst_n`) clears all outputs to 0.
- R2: With `op_sel` = 2'b10 (equal), `result` is 1 when neither operand is a NaN and both hold the same numeric value, and 0 otherwise.
- R3: With `op_sel` = 2'b01 (less-than), `result` is 1 when neither operand is a NaN and a is numerically below b. Among negative values, the larger magnitude is the smaller number.
- R4: With `op_sel` = 2'b00 (less-or-equal), `result` is 1 when neither operand is a NaN and a is below or equal to b.
- R5: +0 and -0 are equal in any pairing. Equal and less-or-equal return 1 for them, and less-than returns 0.
- R6: -inf is below every finite value and +inf is above every finite value. Two infinities of the same sign are equal. Subnormals order by their value like any finite number.
- R7: An operand is a NaN when exponent bits 62:52 are all ones and fraction bits 51:0 are nonzero. It is quiet when bit 51 is 1 and signaling when bit 51 is 0.
- R8: For equal, any NaN operand yields result 0. The invalid flag (`flags` bit 4, value 5'h10) is set only if at least one operand is a signaling NaN. A quiet NaN alone leaves `flags` at 0.
- R9: For less-than and less-or-equal, a NaN in either or both operands, quiet or signaling, yields result 0 and `flags` = 5'h10.
- R10: `flags` bits 3:0 and `result` bits XLEN-1:1 are always 0.
- R11: `op_sel` = 2'b11 is reserved. It yields result 0 and flags 0, even with signaling NaN operands.
- R12: After a cycle with `in_valid` low, `result` and `flags` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request strobe |
| op_sel | input | 2 | 00 less-or-equal, 01 less-than, 10 equal, 11 reserved |
| opnd_a | input | 64 | Left operand, binary64 |
| opnd_b | input | 64 | Right operand, binary64 |
| out_valid | output | 1 | Answer valid, one cycle after request |
| result | output | XLEN | Comparison bit in bit 0, upper bits zero |
| flags | output | 5 | Exception flags; bit 4 invalid, bits 3:0 zero |

## Verification
The only internal state is the single output register stage. A fault in it shows on the very next cycle as a wrong `result` bit, a wrong invalid bit, or a valid that is stuck or shifted. A misclassified operand shows in the same way one cycle after the request. A quiet/signaling mix-up appears only with equal, through the invalid bit. A sign or magnitude error appears as a flipped answer for negative pairs, zero pairs or infinities. The bench therefore aims its directed vectors at those boundaries and compares every output on every cycle.

// File: rtl/fp64_cmp_pkg.sv
package fp64_cmp_pkg;

  localparam int FP_W    = 64;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int MAG_W   = FP_W - 1;
  localparam int QBIT    = FRAC_W - 1;
  localparam int FLAG_W  = 5;
  localparam int FLAG_NV = 4;

  typedef enum logic [1:0] {
    OP_LE  = 2'b00,
    OP_LT  = 2'b01,
    OP_EQ  = 2'b10,
    OP_RSV = 2'b11
  } cmp_op_e;

  typedef struct packed {
    logic             sign;
    logic             is_zero;
    logic             is_nan;
    logic             is_snan;
    logic [MAG_W-1:0] mag;
  } fp_class_t;

  // Decode the raw bit pattern into the attributes the comparison needs.
  function automatic fp_class_t classify(input logic [FP_W-1:0] x);
    fp_class_t c;
    logic exp_ones;
    logic frac_nz;
    exp_ones  = &x[FP_W-2 -: EXP_W];
    frac_nz   = |x[FRAC_W-1:0];
    c.sign    = x[FP_W-1];
    c.mag     = x[MAG_W-1:0];
    c.is_zero = ~|x[MAG_W-1:0];
    c.is_nan  = exp_ones & frac_nz;
    c.is_snan = exp_ones & frac_nz & ~x[QBIT];
    return c;
  endfunction

  // Strict numeric order of two non-NaN sign-magnitude values.
  function automatic logic sm_less(input logic sa, input logic [MAG_W-1:0] ma,
                                   input logic sb, input logic [MAG_W-1:0] mb,
                                   input logic both_zero);
    logic r;
    if (both_zero)        r = 1'b0;
    else if (sa != sb)    r = sa;
    else if (!sa)         r = (ma < mb);
    else                  r = (mb < ma);
    return r;
  endfunction

  // Numeric equality of two non-NaN sign-magnitude values.
  function automatic logic sm_equal(input logic sa, input logic [MAG_W-1:0] ma,
                                    input logic sb, input logic [MAG_W-1:0] mb,
                                    input logic both_zero);
    return both_zero | ((sa == sb) & (ma == mb));
  endfunction

endpackage

// File: rtl/fp64_classify.sv
module fp64_classify
  import fp64_cmp_pkg::*;
(
  input  logic [FP_W-1:0] operand,
  output fp_class_t       cls
);
  always_comb cls = classify(operand);
endmodule

// File: rtl/fp64_order.sv
module fp64_order
  import fp64_cmp_pkg::*;
(
  input  logic             sign_a,
  input  logic             zero_a,
  input  logic [MAG_W-1:0] mag_a,
  input  logic             sign_b,
  input  logic             zero_b,
  input  logic [MAG_W-1:0] mag_b,
  output logic             ord_eq,
  output logic             ord_lt
);
  logic both_zero;
  always_comb begin
    both_zero = zero_a & zero_b;
    ord_eq    = sm_equal(sign_a, mag_a, sign_b, mag_b, both_zero);
    ord_lt    = sm_less (sign_a, mag_a, sign_b, mag_b, both_zero);
  end
endmodule

// File: rtl/fp64_cmp_decide.sv
module fp64_cmp_decide
  import fp64_cmp_pkg::*;
(
  input  logic [1:0] op_sel,
  input  logic       nan_a,
  input  logic       snan_a,
  input  logic       nan_b,
  input  logic       snan_b,
  input  logic       ord_eq,
  input  logic       ord_lt,
  output logic       res_bit,
  output logic       invalid,
  output logic       any_nan,
  output logic       any_snan
);
  always_comb begin
    any_nan  = nan_a | nan_b;
    any_snan = snan_a | snan_b;
    res_bit  = 1'b0;
    invalid  = 1'b0;
    unique case (cmp_op_e'(op_sel))
      OP_EQ: begin
        res_bit = ~any_nan & ord_eq;
        invalid = any_snan;
      end
      OP_LT: begin
        res_bit = ~any_nan & ord_lt;
        invalid = any_nan;
      end
      OP_LE: begin
        res_bit = ~any_nan & (ord_lt | ord_eq);
        invalid = any_nan;
      end
      default: begin
        res_bit = 1'b0;
        invalid = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fp64_cmp_unit.sv
module fp64_cmp_unit
  import fp64_cmp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic [FP_W-1:0]   opnd_a,
  input  logic [FP_W-1:0]   opnd_b,
  output logic              out_valid,
  output logic [XLEN-1:0]   result,
  output logic [FLAG_W-1:0] flags
);
  localparam int NOPND = 2;

  logic [FP_W-1:0] opnd_vec [NOPND];
  fp_class_t       cls_vec  [NOPND];

  assign opnd_vec[0] = opnd_a;
  assign opnd_vec[1] = opnd_b;

  for (genvar g = 0; g < NOPND; g++) begin : g_cls
    fp64_classify u_cls (.operand(opnd_vec[g]), .cls(cls_vec[g]));
  end

  // Named internal events, visible to the bound checker.
  logic ord_eq_w, ord_lt_w, res_bit_w, invalid_w, any_nan_w, any_snan_w;

  fp64_order u_order (
    .sign_a (cls_vec[0].sign), .zero_a(cls_vec[0].is_zero), .mag_a(cls_vec[0].mag),
    .sign_b (cls_vec[1].sign), .zero_b(cls_vec[1].is_zero), .mag_b(cls_vec[1].mag),
    .ord_eq (ord_eq_w),        .ord_lt(ord_lt_w)
  );

  fp64_cmp_decide u_decide (
    .op_sel  (op_sel),
    .nan_a   (cls_vec[0].is_nan), .snan_a(cls_vec[0].is_snan),
    .nan_b   (cls_vec[1].is_nan), .snan_b(cls_vec[1].is_snan),
    .ord_eq  (ord_eq_w),          .ord_lt(ord_lt_w),
    .res_bit (res_bit_w),         .invalid(invalid_w),
    .any_nan (any_nan_w),         .any_snan(any_snan_w)
  );

  logic vld_q, res_q, nv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= 1'b0;
      nv_q  <= 1'b0;
    end else begin
      vld_q <= in_valid;
      res_q <= in_valid & res_bit_w;
      nv_q  <= in_valid & invalid_w;
    end
  end

  always_comb begin
    out_valid          = vld_q;
    result             = '0;
    result[0]          = res_q;
    flags              = '0;
    flags[FLAG_NV]     = nv_q;
  end
endmodule

// File: rtl/fp64_cmp_checker.sv
module fp64_cmp_checker
  import fp64_cmp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        op_sel,
  input logic              out_valid,
  input logic [XLEN-1:0]   result,
  input logic [FLAG_W-1:0] flags,
  input logic              any_nan_w,
  input logic              any_snan_w
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> out_valid == $past(in_valid));

  p_unused_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FLAG_NV-1:0] == '0 && result[XLEN-1:1] == '0);

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(in_valid)) |-> (result == '0 && flags == '0));

  p_reserved_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid && op_sel == 2'b11)) |-> (result == '0 && flags == '0));

  p_ordered_nan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid && !op_sel[1] && any_nan_w))
      |-> (result == '0 && flags == 5'h10));

  p_eq_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid && op_sel == 2'b10 && any_nan_w))
      |-> (result == '0 && flags[FLAG_NV] == $past(any_snan_w)));
endmodule

bind fp64_cmp_unit fp64_cmp_checker #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .out_valid (out_valid),
  .result    (result),
  .flags     (flags),
  .any_nan_w (any_nan_w),
  .any_snan_w(any_snan_w)
);

// File: tb/fp64_cmp_unit_test.sv
module fp64_cmp_unit_test;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [1:0]      op_sel = 2'b00;
  logic [63:0]     opnd_a = '0;
  logic [63:0]     opnd_b = '0;
  logic            out_valid;
  logic [XLEN-1:0] result;
  logic [4:0]      flags;

  fp64_cmp_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result), .flags(flags)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Expected-output queue: one entry per cycle.
  logic [XLEN-1:0] exp_res_q [$];
  logic [4:0]      exp_flg_q [$];
  logic            exp_vld_q [$];
  string           exp_tag_q [$];

  localparam logic [63:0] NEG136 = 64'hBFF5C28F5C28F5C3;
  localparam logic [63:0] NEG137 = 64'hBFF5EB851EB851EC;
  localparam logic [63:0] QNAN   = 64'h7FF8000000000000;
  localparam logic [63:0] QNAN2  = 64'hFFFFFFFFFFFFFFFF;
  localparam logic [63:0] SNAN   = 64'h7FF4000000000000;
  localparam logic [63:0] SNAN1  = 64'h7FF0000000000001;
  localparam logic [63:0] PZERO  = 64'h0;
  localparam logic [63:0] NZERO  = 64'h8000000000000000;
  localparam logic [63:0] PINF   = 64'h7FF0000000000000;
  localparam logic [63:0] NINF   = 64'hFFF0000000000000;
  localparam logic [63:0] ONE    = 64'h3FF0000000000000;
  localparam logic [63:0] MAXF   = 64'h7FEFFFFFFFFFFFFF;
  localparam logic [63:0] SUBN   = 64'h0000000000000001;
  localparam logic [63:0] NSUBN  = 64'h8000000000000001;

  // R7: NaN = all-ones exponent and nonzero fraction; bit 51 separates kinds.
  function automatic bit m_nan(logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction
  function automatic bit m_snan(logic [63:0] x);
    return m_nan(x) && !x[51];
  endfunction
  // Monotonic integer key: a below b iff key(a) below key(b); zeros merged.
  function automatic logic [63:0] m_key(logic [63:0] x);
    logic [63:0] y = x;
    if (y[62:0] == 0) y = 64'h0;
    return y[63] ? ~y : (y | 64'h8000000000000000);
  endfunction

  task automatic expect_for(input bit v, input logic [1:0] op,
                            input logic [63:0] a, input logic [63:0] b, input string tag);
    bit nan_any = m_nan(a) || m_nan(b);
    bit snan_any = m_snan(a) || m_snan(b);
    bit r = 0;
    bit nv = 0;
    if (v) begin
      case (op)
        2'b10: begin r = !nan_any && (m_key(a) == m_key(b)); nv = snan_any; end
        2'b01: begin r = !nan_any && (m_key(a) <  m_key(b)); nv = nan_any;  end
        2'b00: begin r = !nan_any && (m_key(a) <= m_key(b)); nv = nan_any;  end
        default: begin r = 0; nv = 0; end
      endcase
    end
    exp_vld_q.push_back(v);
    exp_res_q.push_back({{(XLEN-1){1'b0}}, r});
    exp_flg_q.push_back({nv, 4'b0});
    exp_tag_q.push_back(tag);
  endtask

  task automatic compare_out();
    logic [XLEN-1:0] er;
    logic [4:0] ef;
    logic ev;
    string t;
    if (exp_vld_q.size() == 0) return;
    ev = exp_vld_q.pop_front(); er = exp_res_q.pop_front();
    ef = exp_flg_q.pop_front(); t  = exp_tag_q.pop_front();
    checks++;
    if (out_valid !== ev || result !== er || flags !== ef) begin
      errors++;
      $display("FAIL %s: vld/res/flags = %0b/%h/%h expected %0b/%h/%h",
               t, out_valid, result, flags, ev, er, ef);
    end
  endtask

  // Drive one cycle at the falling edge; check the previous cycle's answer first.
  task automatic step(input bit v, input logic [1:0] op,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    compare_out();
    in_valid = v; op_sel = op; opnd_a = a; opnd_b = b;
    expect_for(v, op, a, b, tag);
    @(negedge clk);
  endtask

  function automatic string auto_tag(bit v, logic [1:0] op, logic [63:0] a, logic [63:0] b);
    if (!v) return "R12";
    if (op == 2'b11) return "R11";
    if (m_nan(a) || m_nan(b)) return (op == 2'b10) ? "R8" : "R9";
    if (a[62:0] == 0 && b[62:0] == 0) return "R5";
    if (a[62:52] == 11'h7FF || b[62:52] == 11'h7FF || a[62:52] == 0 || b[62:52] == 0) return "R6";
    case (op)
      2'b10: return "R2";
      2'b01: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic run(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    step(1'b1, op, a, b, auto_tag(1'b1, op, a, b));
  endtask

  function automatic logic [63:0] pick(int unsigned s);
    case (s % 16)
      0: return NEG136;  1: return NEG137;  2: return QNAN;  3: return QNAN2;
      4: return SNAN;    5: return SNAN1;   6: return PZERO; 7: return NZERO;
      8: return PINF;    9: return NINF;   10: return ONE;  11: return MAXF;
      12: return SUBN;  13: return NSUBN;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || flags !== '0) begin
      errors++;
      $display("FAIL R1: reset outputs %0b/%h/%h expected 0/0/0", out_valid, result, flags);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R4: identical and ordered negatives
    run(2'b10, NEG136, NEG136);
    run(2'b00, NEG136, NEG136);
    run(2'b01, NEG136, NEG136);
    run(2'b10, NEG137, NEG136);
    run(2'b00, NEG137, NEG136);
    run(2'b01, NEG137, NEG136);
    run(2'b01, NEG136, NEG137);
    run(2'b01, ONE, MAXF);
    run(2'b00, MAXF, ONE);
    // R5: signed zeros
    step(1'b1, 2'b10, PZERO, NZERO, "R5");
    step(1'b1, 2'b01, NZERO, PZERO, "R5");
    step(1'b1, 2'b00, PZERO, NZERO, "R5");
    // R6: infinities and subnormals
    step(1'b1, 2'b01, NINF, NEG137, "R6");
    step(1'b1, 2'b01, MAXF, PINF, "R6");
    step(1'b1, 2'b10, PINF, PINF, "R6");
    step(1'b1, 2'b01, NSUBN, SUBN, "R6");
    step(1'b1, 2'b01, PZERO, SUBN, "R6");
    // R7/R8: quiet vs signaling by bit 51 under equal
    step(1'b1, 2'b10, QNAN, PZERO, "R8");
    step(1'b1, 2'b10, QNAN, QNAN, "R8");
    step(1'b1, 2'b10, SNAN, PZERO, "R8");
    step(1'b1, 2'b10, ONE, SNAN1, "R7");
    step(1'b1, 2'b10, QNAN2, ONE, "R7");
    // R9: ordered compares with any NaN
    step(1'b1, 2'b01, QNAN, PZERO, "R9");
    step(1'b1, 2'b01, QNAN, QNAN, "R9");
    step(1'b1, 2'b01, SNAN, PZERO, "R9");
    step(1'b1, 2'b00, QNAN, PZERO, "R9");
    step(1'b1, 2'b00, PINF, QNAN2, "R9");
    step(1'b1, 2'b00, SNAN, PZERO, "R9");
    // R11: reserved code
    step(1'b1, 2'b11, SNAN, SNAN, "R11");
    step(1'b1, 2'b11, ONE, ONE, "R11");
    // R12 / R1: idle cycles between requests
    step(1'b0, 2'b10, ONE, ONE, "R12");
    step(1'b1, 2'b10, ONE, ONE, "R1");
    step(1'b0, 2'b01, SNAN, ONE, "R12");

    // R10 and mixed coverage: random pairs from the boundary pool
    for (int i = 0; i < 600; i++) begin
      bit v = ($urandom() % 8) != 0;
      logic [1:0] op = 2'($urandom());
      logic [63:0] a = pick($urandom());
      logic [63:0] b = (($urandom() % 4) == 0) ? a : pick($urandom());
      step(v, op, a, b, auto_tag(v, op, a, b));
    end
    step(1'b0, 2'b00, '0, '0, "R12");
    compare_out();
    finish_run();
  end
endmodule